// File: doc/BRIEF.md
# Linked-Descriptor Card DMA Engine

This block moves a data transfer between system memory and a card data port without processor help. Software builds a chain of descriptors in memory. Each descriptor is four 32-bit words: a status word, a buffer size, a buffer address and the address of the next descriptor. Software then gives the engine the address of the first descriptor, a total byte count, a block size, an enable and a direction, and pulses start. The engine fetches each descriptor in turn and moves its share of the data one 32-bit word per handshake. It then hands the descriptor back by writing its status word with the ownership bit cleared.

A transfer ends at a descriptor marked last, or as soon as the remaining byte count reaches zero, whichever comes first. The engine then latches its completion flags and pulses done. The memory side is a simple request/acknowledge master. The card side is a word stream gated by a single ready flag, which also tells the engine whether receive data exists at all. Either side can stall the engine for any number of cycles.

Top module: `desc_dma_engine`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o, card_rd_o and card_wr_o are 0, and raw_stat_o, dma_stat_o and bytes_left_o are all zero.
- R2: A start pulse is refused if byte_count_i is 0, block_size_i is 0, dma_en_i is 0, or dir_write_i is 0 (card-to-memory) while card_ready_i is 0. A refused start makes no memory request and no card strobe, busy_o stays 0, and both status outputs keep their values.
- R3: Descriptor words are read at ascending addresses d, d+4, d+8, d+12 and hold status, size, buffer address and next address, in that order. Status bit 31 means owned by the engine and bit 2 marks the last descriptor.
- R4: A size field of 0, or one above MAX_DESC_BYTES, is taken as MAX_DESC_BYTES. Any other size is used as given.
- R5: Each descriptor moves chunk = min(effective size, remaining bytes), which is ceil(chunk/4) words at ascending word addresses starting from the buffer address with its low two bits cleared. The remaining count drops by chunk, and bytes_left_o shows it after completion.
- R6: With dir_write_i=1, each word is read from memory and then written to the card. With dir_write_i=0, each word is read from the card and then written to memory.
- R7: After a descriptor's data has moved, its status word is written back to the descriptor address with bit 31 cleared and every other bit as read. Descriptors the walk never reaches are not written.
- R8: The walk stops after a descriptor with bit 2 set, or when the remaining count reaches zero. Otherwise it continues at the address held in the descriptor's next word.
- R9: On completion, raw_stat_o has bits 3 and 16 set. dma_stat_o has bit 8 set, plus bit 0 for a memory-to-card transfer or bit 1 for a card-to-memory transfer. The flags stay set until the next accepted start.
- R10: done_o is a one-cycle pulse in the cycle right after the final status write-back is acknowledged, and the R9 flags are already visible in that cycle.
- R11: A start pulse that arrives while busy_o is 1 has no effect on the running transfer.
- R12: A memory request holds its address, direction and write data stable until mem_ack_i. A card word moves only in a cycle where card_ready_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| dir_write_i | input | 1 | 1: memory to card, 0: card to memory |
| dma_en_i | input | 1 | Engine enable |
| byte_count_i | input | BCW | Total bytes to move |
| block_size_i | input | BCW | Block size; zero refuses the start |
| desc_base_i | input | 32 | Address of the first descriptor |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory accepted the request (read data valid) |
| mem_rdata_i | input | 32 | Memory read data |
| card_ready_i | input | 1 | Card can accept or supply a word |
| card_rd_o | output | 1 | Word taken from card this cycle |
| card_rdata_i | input | 32 | Card receive word |
| card_wr_o | output | 1 | Word given to card this cycle |
| card_wdata_o | output | 32 | Card transmit word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| bytes_left_o | output | BCW | Remaining byte count |
| raw_stat_o | output | 32 | Latched raw completion flags |
| dma_stat_o | output | 32 | Latched engine completion flags |

## Verification
The hardest case to reach is a walk that ends for one reason while the other reason is still far away. One example is a last-marked descriptor that stops the walk with bytes still owed. Another is a count that runs out partway through a chain whose last flag sits on a later descriptor, so that descriptor must stay untouched. A third is a final chunk that is not a whole number of words. The bench builds chains with their descriptors placed in memory in reverse order and with junk in the buffer address's low bits. It uses sizes of zero, oversize and odd values, and runs every chain in both directions. Each run is repeated with memory acknowledges and card ready dropping on a fixed cycle pattern, so that every state has to wait, and a second start is fired into each run.

// File: rtl/dde_pkg.sv
package dde_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_MRD, S_CWR, S_CRD, S_MWR, S_WB, S_FIN
  } dde_state_e;

  localparam int unsigned ST_OWN   = 31;
  localparam int unsigned ST_LAST  = 2;
  localparam int unsigned RAW_DONE = 3;
  localparam int unsigned RAW_EVT  = 16;
  localparam int unsigned DST_SUM  = 8;
  localparam int unsigned DST_TX   = 0;
  localparam int unsigned DST_RX   = 1;
endpackage

// File: rtl/desc_size_clamp.sv
module desc_size_clamp #(
  parameter int unsigned MAX_BYTES = 8192,
  parameter int unsigned OW        = $clog2(MAX_BYTES) + 1
) (
  input  logic [31:0]   size_i,
  output logic [OW-1:0] size_o
);
  localparam logic [31:0] MAX_W = 32'(MAX_BYTES);

  always_comb begin
    if (size_i == '0 || size_i > MAX_W) size_o = OW'(MAX_BYTES);
    else                                size_o = size_i[OW-1:0];
  end
endmodule

// File: rtl/dde_status.sv
module dde_status
  import dde_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        set_i,
  input  logic        write_i,
  output logic [31:0] raw_o,
  output logic [31:0] dma_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o <= '0;
      dma_o <= '0;
    end else if (clr_i) begin
      raw_o <= '0;
      dma_o <= '0;
    end else if (set_i) begin
      raw_o[RAW_DONE] <= 1'b1;
      raw_o[RAW_EVT]  <= 1'b1;
      dma_o[DST_SUM]  <= 1'b1;
      if (write_i) dma_o[DST_TX] <= 1'b1;
      else         dma_o[DST_RX] <= 1'b1;
    end
  end
endmodule

// File: rtl/desc_dma_engine.sv
module desc_dma_engine
  import dde_pkg::*;
#(
  parameter int unsigned MAX_DESC_BYTES = 8192,
  parameter int unsigned BCW            = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           dir_write_i,
  input  logic           dma_en_i,
  input  logic [BCW-1:0] byte_count_i,
  input  logic [BCW-1:0] block_size_i,
  input  logic [31:0]    desc_base_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [31:0]    mem_addr_o,
  output logic [31:0]    mem_wdata_o,
  input  logic           mem_ack_i,
  input  logic [31:0]    mem_rdata_i,
  input  logic           card_ready_i,
  output logic           card_rd_o,
  input  logic [31:0]    card_rdata_i,
  output logic           card_wr_o,
  output logic [31:0]    card_wdata_o,
  output logic           busy_o,
  output logic           done_o,
  output logic [BCW-1:0] bytes_left_o,
  output logic [31:0]    raw_stat_o,
  output logic [31:0]    dma_stat_o
);
  localparam int unsigned SZW = $clog2(MAX_DESC_BYTES) + 1;
  localparam int unsigned WCW = SZW - 1;

  dde_state_e     state_q;
  logic [1:0]     widx_q;
  logic [31:0]    desc_q, st_q, size_q, buf_q, next_q, off_q, dq;
  logic [BCW-1:0] rem_q;
  logic [WCW-1:0] wl_q;
  logic           dir_q;

  logic [SZW-1:0] eff_sz, chunk;
  logic [SZW:0]   chunk_rnd;
  logic [WCW-1:0] nwords;
  logic           go, fin_cond, last_word, set_flags;
  logic [31:0]    buf_base;

  desc_size_clamp #(.MAX_BYTES(MAX_DESC_BYTES), .OW(SZW)) u_clamp (
    .size_i(size_q),
    .size_o(eff_sz)
  );

  always_comb begin
    chunk     = (rem_q < BCW'(eff_sz)) ? rem_q[SZW-1:0] : eff_sz;
    chunk_rnd = {1'b0, chunk} + (SZW+1)'(3);
    nwords    = chunk_rnd[SZW:2];
  end

  assign go = start_i && dma_en_i && (byte_count_i != '0) && (block_size_i != '0)
              && (dir_write_i || card_ready_i);
  assign fin_cond  = st_q[ST_LAST] || (rem_q == '0);
  assign last_word = (wl_q == WCW'(1));
  assign buf_base  = {buf_q[31:2], 2'b00};
  assign set_flags = (state_q == S_WB) && mem_ack_i && fin_cond;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      widx_q  <= '0;
      desc_q  <= '0;
      st_q    <= '0;
      size_q  <= '0;
      buf_q   <= '0;
      next_q  <= '0;
      off_q   <= '0;
      dq      <= '0;
      rem_q   <= '0;
      wl_q    <= '0;
      dir_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (go) begin
          dir_q   <= dir_write_i;
          rem_q   <= byte_count_i;
          desc_q  <= desc_base_i;
          widx_q  <= '0;
          state_q <= S_FETCH;
        end
        S_FETCH: if (mem_ack_i) begin
          widx_q <= widx_q + 2'd1;
          case (widx_q)
            2'd0: st_q   <= mem_rdata_i;
            2'd1: size_q <= mem_rdata_i;
            2'd2: buf_q  <= mem_rdata_i;
            default: begin
              next_q  <= mem_rdata_i;
              rem_q   <= rem_q - BCW'(chunk);
              wl_q    <= nwords;
              off_q   <= '0;
              state_q <= dir_q ? S_MRD : S_CRD;
            end
          endcase
        end
        S_MRD: if (mem_ack_i) begin
          dq      <= mem_rdata_i;
          state_q <= S_CWR;
        end
        S_CWR: if (card_ready_i) begin
          off_q   <= off_q + 32'd4;
          wl_q    <= wl_q - WCW'(1);
          state_q <= last_word ? S_WB : S_MRD;
        end
        S_CRD: if (card_ready_i) begin
          dq      <= card_rdata_i;
          state_q <= S_MWR;
        end
        S_MWR: if (mem_ack_i) begin
          off_q   <= off_q + 32'd4;
          wl_q    <= wl_q - WCW'(1);
          state_q <= last_word ? S_WB : S_CRD;
        end
        S_WB: if (mem_ack_i) begin
          if (fin_cond) state_q <= S_FIN;
          else begin
            desc_q  <= next_q;
            widx_q  <= '0;
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_q + {28'd0, widx_q, 2'b00};
      end
      S_MRD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = buf_base + off_q;
      end
      S_MWR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_base + off_q;
        mem_wdata_o = dq;
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q;
        mem_wdata_o = st_q & ~(32'd1 << ST_OWN);
      end
      default: ;
    endcase
  end

  assign card_rd_o    = (state_q == S_CRD) && card_ready_i;
  assign card_wr_o    = (state_q == S_CWR) && card_ready_i;
  assign card_wdata_o = dq;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_FIN);
  assign bytes_left_o = rem_q;

  dde_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  ((state_q == S_IDLE) && go),
    .set_i  (set_flags),
    .write_i(dir_q),
    .raw_o  (raw_stat_o),
    .dma_o  (dma_stat_o)
  );

  p_req_held_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_done_after_wb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> raw_stat_o[RAW_DONE] && raw_stat_o[RAW_EVT] && dma_stat_o[DST_SUM]
               && (dma_stat_o[DST_TX] != dma_stat_o[DST_RX]));

  p_wb_own_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WB) |-> mem_we_o && (mem_addr_o == desc_q) && !mem_wdata_o[ST_OWN]);

  p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && (state_q != S_WB) |=> $stable(desc_q) && $stable(dir_q));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !card_rd_o && !card_wr_o);
endmodule

// File: tb/tb_desc_dma_engine.sv
`timescale 1ns/1ps
module tb_desc_dma_engine;
  localparam int MAXB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 0, dir_wr = 0, en = 0;
  logic [31:0] bc = 0, bs = 0, base = 0;
  logic        mem_req, mem_we, mem_ack, card_rd, card_wr, card_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, card_wdata;
  logic        busy, done;
  logic [31:0] bytes_left, raw_stat, dma_stat;

  logic [31:0] mem [0:511];
  logic [31:0] cap [0:63];
  logic        ack_q = 0;
  logic [31:0] rdata_q = 0;
  logic [31:0] src = 0;
  int          cap_n = 0, req_cnt = 0, cyc = 0, last_wr = -10;
  int          mode = 0;
  logic        force_low = 0;
  int          checks = 0, fails = 0;

  assign mem_ack   = ack_q;
  assign mem_rdata = rdata_q;
  assign card_rdy  = force_low ? 1'b0 : (!busy ? 1'b1 : (mode == 0 || (cyc % 4) != 2));

  desc_dma_engine #(.MAX_DESC_BYTES(MAXB), .BCW(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_write_i(dir_wr), .dma_en_i(en),
    .byte_count_i(bc), .block_size_i(bs), .desc_base_i(base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .card_ready_i(card_rdy), .card_rd_o(card_rd), .card_rdata_i(src),
    .card_wr_o(card_wr), .card_wdata_o(card_wdata),
    .busy_o(busy), .done_o(done), .bytes_left_o(bytes_left),
    .raw_stat_o(raw_stat), .dma_stat_o(dma_stat));

  // memory and card models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !ack_q && (mode == 0 || (cyc % 3) != 0)) begin
      ack_q   <= 1'b1;
      rdata_q <= mem[mem_addr[10:2]];
      if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
      req_cnt <= req_cnt + 1;
    end else ack_q <= 1'b0;
    if (ack_q && mem_req && mem_we) last_wr <= cyc;
    if (card_rd) src <= src + 1;
    if (card_wr) begin
      if (cap_n < 64) cap[cap_n] <= card_wdata;
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int daddr(input int i);
    return 32'h100 - (i + 1) * 32'h20;
  endfunction

  function automatic logic [31:0] pat(input int c, input int i, input int k);
    return 32'h1000_0000 + (c << 16) + (i << 8) + k;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_case(input int c, input bit wr);
    int sz[4]; bit lst[4]; int total;
    logic [31:0] orig[4];
    logic [31:0] src0;
    int rem, g, t, nd_done;
    bit stop;
    case (c)
      0: begin sz = '{12, 12, 12, 12}; lst = '{0, 0, 0, 1}; total = 30;   end
      1: begin sz = '{0, 100, 8, 4};   lst = '{0, 0, 0, 1}; total = 200;  end
      2: begin sz = '{5, 64, 20, 0};   lst = '{0, 1, 0, 0}; total = 1000; end
      default: begin sz = '{64, 0, 0, 0}; lst = '{0, 0, 0, 0}; total = 130; end
    endcase
    for (int w = 0; w < 512; w++) mem[w] = 32'h5A5A_0000 + w;
    for (int i = 0; i < 4; i++) begin
      orig[i] = 32'h8000_0010 | (i == 0 ? 32'h8 : 32'h0) | (lst[i] ? 32'h4 : 32'h0);
      mem[daddr(i) / 4]     = orig[i];
      mem[daddr(i) / 4 + 1] = sz[i];
      mem[daddr(i) / 4 + 2] = 32'h400 + i * 32'h40 + i;
      mem[daddr(i) / 4 + 3] = daddr(i + 1);
      if (wr) for (int k = 0; k < 16; k++) mem[256 + i * 16 + k] = pat(c, i, k);
    end
    src0 = 32'h7000_0000 + (c << 8) + (wr ? 0 : 32'h80);
    @(negedge clk);
    cap_n = 0; src = src0;
    dir_wr = wr; bc = total; bs = 512; en = 1; base = daddr(0);
    pulse_start();
    repeat (3) @(negedge clk);
    // R11: second start while busy, with another base and direction
    base = 32'h1F0; dir_wr = ~wr;
    pulse_start();
    base = daddr(0); dir_wr = wr;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, "R10", "done seen", t, 0);
    chk(cyc == last_wr + 1, "R10", "done one cycle after write-back", cyc, last_wr + 1);
    chk(raw_stat == 32'h0001_0008, "R9", "raw flags at done", raw_stat, 32'h0001_0008);
    chk(dma_stat == (32'h100 | (wr ? 1 : 2)), "R9", "dma flags at done", dma_stat,
        32'h100 | (wr ? 1 : 2));
    @(negedge clk);
    chk(!done, "R10", "done is a single pulse", done, 0);
    chk(!busy, "R11", "idle after one run", busy, 0);
    // expected walk from the requirements
    rem = total; g = 0; stop = 0; nd_done = 0;
    for (int i = 0; i < 4 && !stop; i++) begin
      int es, ch, nw;
      es = (sz[i] == 0 || sz[i] > MAXB) ? MAXB : sz[i];
      ch = (rem < es) ? rem : es;
      nw = (ch + 3) / 4;
      for (int k = 0; k < nw; k++) begin
        if (wr) chk(g < 64 && cap[g] == pat(c, i, k), "R6", "card word",
                    cap[g], pat(c, i, k));
        else    chk(mem[256 + i * 16 + k] == src0 + g, "R5", "memory word",
                    mem[256 + i * 16 + k], src0 + g);
        g++;
      end
      if (!wr && nw < 16)
        chk(mem[256 + i * 16 + nw] == 32'h5A5A_0000 + 256 + i * 16 + nw, "R5",
            "word past chunk untouched", mem[256 + i * 16 + nw],
            32'h5A5A_0000 + 256 + i * 16 + nw);
      chk(mem[daddr(i) / 4] == (orig[i] & 32'h7FFF_FFFF), "R7", "write-back status",
          mem[daddr(i) / 4], orig[i] & 32'h7FFF_FFFF);
      rem = rem - ch;
      nd_done = i + 1;
      if (lst[i] || rem == 0) stop = 1;
    end
    if (nd_done < 4)
      chk(mem[daddr(nd_done) / 4] == orig[nd_done], "R8", "unreached descriptor kept",
          mem[daddr(nd_done) / 4], orig[nd_done]);
    chk(bytes_left == rem, "R5", "bytes left", bytes_left, rem);
    if (wr) chk(cap_n == g, "R6", "card words written", cap_n, g);
    else    chk(src - src0 == g, "R6", "card words read", src - src0, g);
  endtask

  task automatic run_refused(input int which);
    int r0; logic [31:0] rs, ds; bit saw;
    @(negedge clk);
    r0 = req_cnt; rs = raw_stat; ds = dma_stat;
    dir_wr = 1; bc = 16; bs = 512; en = 1; base = daddr(0); force_low = 0;
    case (which)
      0: bc = 0;
      1: bs = 0;
      2: en = 0;
      default: begin dir_wr = 0; force_low = 1; end
    endcase
    pulse_start();
    saw = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy) saw = 1; end
    chk(!saw, "R2", "refused start stays idle", saw, 0);
    chk(req_cnt == r0, "R2", "refused start makes no request", req_cnt, r0);
    chk(raw_stat == rs && dma_stat == ds, "R2", "refused start keeps flags",
        raw_stat, rs);
    force_low = 0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !card_rd && !card_wr, "R1", "reset outputs",
        {busy, done, mem_req, card_rd, card_wr}, 0);
    chk(raw_stat == 0 && dma_stat == 0 && bytes_left == 0, "R1", "reset values",
        raw_stat | dma_stat | bytes_left, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1", "idle after reset release", busy, 0);
    for (int m = 0; m < 2; m++) begin
      mode = m;
      for (int c = 0; c < 4; c++) begin
        run_case(c, 1'b1);  // R4 R5 R6 R7 R8 memory to card
        run_case(c, 1'b0);  // R3 R12 card to memory
      end
    end
    for (int w = 0; w < 4; w++) run_refused(w);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule